// File: doc/BRIEF.md
# DMA Channel Register Block

This block is the register file of a single channel of a descriptor-style DMA engine. It sits on a 32-bit register bus. A control word accepts one-shot command bits, and four status flags report enable, chain update, transfer direction and completion. Next to the control word are 32-bit pointer registers: the current transfer pointer, its limit, a start and a stop pointer, and an initial-buffer pointer. A second, staged copy of the first four pointers describes the buffer that follows in the chain.

The data engine signals each completed word with a one-cycle beat. While the channel is enabled, each beat moves the current pointer forward by one word. When the pointer reaches the limit, the completion flag is set and a one-cycle interrupt pulse is emitted. At that point the channel either loads the staged pointer set and carries on, or stops. Software prepares the next buffer while the current one runs: it raises the chain-update flag and then writes the pointers, which land in the staged set.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset all four flags, all pointers (live, staged and initial-buffer) and the interrupt output are zero, and a control read returns 0.
- R2: A word write to the control word (offset 0x0) with bit 0 set sets the device-to-memory direction flag. Writing 0 to that bit leaves the flag unchanged. The flag reads back in status bit 0.
- R3: Control write bit 1 sets the enable flag (status bit 1), and control write bit 2 sets the chain-update flag (status bit 2). Writing 0 to either bit leaves its flag unchanged.
- R4: Control write bit 3 clears the complete flag (status bit 3).
- R5: Control write bit 4 clears all four flags. It overrides every other command bit in the same write, and a beat arriving in that same cycle is ignored.
- R6: A word read of offset 0x0 returns the four flags in bits 3..0, with zero in all higher bits.
- R7: While the chain-update flag is clear, word writes to 0x4000 (next), 0x4004 (limit), 0x4008 (start) and 0x400C (stop) load the live pointers, and reads return them. Offset 0x4200 is the initial-buffer pointer, a plain read/write register.
- R8: While the chain-update flag is set, writes to offsets 0x4000..0x400C load the staged copy, and the live pointers keep their values.
- R9: When a beat arrives while the channel is enabled, next increases by 4. When the channel is disabled, a beat leaves next unchanged.
- R10: A beat that brings next to equal the limit sets the complete flag. The interrupt output is then high for exactly the following cycle.
- R11: At that boundary, if chain-update is set, all four live pointers take the staged values, chain-update clears and enable stays set. Otherwise enable clears and next holds the limit value.
- R12: Only 32-bit accesses (size code 2) act. Narrower writes are ignored, narrower reads return 0, reads of unmapped offsets return 0, and read data is 0 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte offset within the channel |
| bus_size | input | 2 | Access size code: 0 byte, 1 half, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| xfer_beat | input | 1 | One word moved by the data engine |
| chan_en | output | 1 | Enable flag |
| chan_dir | output | 1 | Device-to-memory flag |
| cur_ptr | output | 32 | Live next pointer |
| irq_pulse | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the following corner cases.

- A design that decoded the control word as plain storage would clear the direction flag when 0 is written to it.
- A reset command combined with set-enable, arriving in the same cycle as a beat, must leave the channel idle with the pointer unmoved. A design that gave either command or the beat precedence over reset would show a set flag or an advanced pointer.
- Pointer writes made while chain-update is set are checked to leave the live set untouched. They are then checked to appear all at once at the boundary, with enable kept set, and the next boundary without chain-update is checked to stop the channel.
- Narrow and unmapped accesses are checked to read zero and to change nothing.

// File: rtl/dma_chan_pkg.sv
// Package: shared encodings for the DMA channel register block.
// Assumes byte offsets on a 32-bit register bus; only the word size code acts.
package dma_chan_pkg;

    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam int unsigned OFS_CSR   = 32'h0000;
    localparam int unsigned OFS_NEXT  = 32'h4000;
    localparam int unsigned OFS_LIMIT = 32'h4004;
    localparam int unsigned OFS_START = 32'h4008;
    localparam int unsigned OFS_STOP  = 32'h400C;
    localparam int unsigned OFS_INIT  = 32'h4200;

    // command bit positions in a control write
    localparam int CMD_DIR     = 0;
    localparam int CMD_SET_EN  = 1;
    localparam int CMD_SET_UPD = 2;
    localparam int CMD_CLR_DONE = 3;
    localparam int CMD_RESET   = 4;

    // pointer indices inside the live and staged banks
    localparam int PIX_NEXT  = 0;
    localparam int PIX_LIMIT = 1;
    localparam int PIX_START = 2;
    localparam int PIX_STOP  = 3;
    localparam int NUM_PTRS  = 4;

    // status flags, packed so that the struct is the status read value
    typedef struct packed {
        logic done;
        logic upd;
        logic en;
        logic dir;
    } chan_flags_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CSR,
        SEL_NEXT,
        SEL_LIMIT,
        SEL_START,
        SEL_STOP,
        SEL_INIT
    } reg_sel_e;

endpackage

// File: rtl/dma_bus_decode.sv
// Module: decodes one register bus access into a write target and a read target.
// Assumes a single access per cycle; narrow sizes and unknown offsets select nothing.
module dma_bus_decode
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    output reg_sel_e          wsel,
    output reg_sel_e          rsel
);

    reg_sel_e hit;
    logic     word_acc;

    // maps the offset to a register, independent of direction
    always_comb begin
        hit = SEL_NONE;
        if (bus_addr == ADDR_W'(OFS_CSR))        hit = SEL_CSR;
        else if (bus_addr == ADDR_W'(OFS_NEXT))  hit = SEL_NEXT;
        else if (bus_addr == ADDR_W'(OFS_LIMIT)) hit = SEL_LIMIT;
        else if (bus_addr == ADDR_W'(OFS_START)) hit = SEL_START;
        else if (bus_addr == ADDR_W'(OFS_STOP))  hit = SEL_STOP;
        else if (bus_addr == ADDR_W'(OFS_INIT))  hit = SEL_INIT;
    end

    assign word_acc = bus_sel && (bus_size == SZ_WORD);

    // splits the hit into the write and read selects
    always_comb begin
        wsel = SEL_NONE;
        rsel = SEL_NONE;
        if (word_acc && bus_wr)  wsel = hit;
        if (word_acc && !bus_wr) rsel = hit;
    end

endmodule

// File: rtl/dma_csr_flags.sv
// Module: the four channel flags and the completion pulse.
// Assumes the advance strong already excludes a reset command in the same cycle.
// Beat effects are computed first; command bits of a control write apply on top.
module dma_csr_flags
    import dma_chan_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              adv,
    input  logic              at_bound,
    output chan_flags_t       flags_q,
    output logic              irq_q
);

    chan_flags_t flags_d;
    logic        bound_hit;

    assign bound_hit = adv && at_bound;

    // next-state of the flags: beat outcome, then command bits
    always_comb begin
        flags_d = flags_q;
        if (bound_hit) begin
            flags_d.done = 1'b1;
            if (flags_q.upd) flags_d.upd = 1'b0;
            else             flags_d.en  = 1'b0;
        end
        if (csr_wr) begin
            if (wdata[CMD_RESET]) begin
                flags_d = '0;
            end else begin
                if (wdata[CMD_DIR])      flags_d.dir  = 1'b1;
                if (wdata[CMD_SET_EN])   flags_d.en   = 1'b1;
                if (wdata[CMD_SET_UPD])  flags_d.upd  = 1'b1;
                if (wdata[CMD_CLR_DONE]) flags_d.done = 1'b0;
            end
        end
    end

    // registers the flags and the one-cycle boundary pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            flags_q <= flags_d;
            irq_q   <= bound_hit;
        end
    end

endmodule

// File: rtl/dma_ptr_bank.sv
// Module: live and staged pointer sets plus the initial-buffer pointer.
// Assumes the write one-hot and the advance strobe never come from a reset cycle's
// beat. Writes go to the staged set while chain-update is set, else to the live set;
// a write in the same cycle as an advance wins for the register written.
module dma_ptr_bank
    import dma_chan_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STEP   = 4,
    parameter int NPTR   = NUM_PTRS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        adv,
    input  logic                        upd_flag,
    input  logic [NPTR-1:0]             wr_ptr,
    input  logic                        wr_init,
    input  logic [DATA_W-1:0]           wdata,
    output logic [NPTR-1:0][DATA_W-1:0] live_q,
    output logic [DATA_W-1:0]           init_q,
    output logic                        at_bound
);

    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

    logic [NPTR-1:0][DATA_W-1:0] saved_q;
    logic [DATA_W-1:0]           next_inc;
    logic                        reload;

    assign next_inc = live_q[PIX_NEXT] + STEP_V;
    assign at_bound = (next_inc == live_q[PIX_LIMIT]);
    assign reload   = adv && at_bound && upd_flag;

    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        // live pointer: direct write, chain reload, or word advance
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q[i] <= '0;
            end else if (wr_ptr[i] && !upd_flag) begin
                live_q[i] <= wdata;
            end else if (reload) begin
                live_q[i] <= saved_q[i];
            end else if (adv && (i == PIX_NEXT)) begin
                live_q[i] <= next_inc;
            end
        end

        // staged pointer: loaded only while chain-update is set
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                saved_q[i] <= '0;
            end else if (wr_ptr[i] && upd_flag) begin
                saved_q[i] <= wdata;
            end
        end
    end

    // initial-buffer pointer: plain storage
    always_ff @(posedge clk) begin
        if (!rst_n)       init_q <= '0;
        else if (wr_init) init_q <= wdata;
    end

endmodule

// File: rtl/dma_chan_regs.sv
// Module: top of one DMA channel register block.
// Assumes one register access per cycle and a beat strobe from the data engine.
// Read data is combinational in the access cycle and zero otherwise.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              xfer_beat,
    output logic              chan_en,
    output logic              chan_dir,
    output logic [DATA_W-1:0] cur_ptr,
    output logic              irq_pulse
);

    localparam int FLAG_W = $bits(chan_flags_t);

    reg_sel_e                        wsel;
    reg_sel_e                        rsel;
    chan_flags_t                     flags_q;
    logic [NUM_PTRS-1:0][DATA_W-1:0] live_ptrs;
    logic [DATA_W-1:0]               init_ptr;
    logic [NUM_PTRS-1:0]             wr_ptr;
    logic                            csr_wr;
    logic                            rst_cmd;
    logic                            adv;
    logic                            at_bound;

    dma_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_size (bus_size),
        .wsel     (wsel),
        .rsel     (rsel)
    );

    assign csr_wr  = (wsel == SEL_CSR);
    assign rst_cmd = csr_wr && bus_wdata[CMD_RESET];
    assign adv     = xfer_beat && flags_q.en && !rst_cmd;

    assign wr_ptr[PIX_NEXT]  = (wsel == SEL_NEXT);
    assign wr_ptr[PIX_LIMIT] = (wsel == SEL_LIMIT);
    assign wr_ptr[PIX_START] = (wsel == SEL_START);
    assign wr_ptr[PIX_STOP]  = (wsel == SEL_STOP);

    dma_csr_flags #(.DATA_W(DATA_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .csr_wr   (csr_wr),
        .wdata    (bus_wdata),
        .adv      (adv),
        .at_bound (at_bound),
        .flags_q  (flags_q),
        .irq_q    (irq_pulse)
    );

    dma_ptr_bank #(.DATA_W(DATA_W), .STEP(STEP), .NPTR(NUM_PTRS)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .upd_flag (flags_q.upd),
        .wr_ptr   (wr_ptr),
        .wr_init  (wsel == SEL_INIT),
        .wdata    (bus_wdata),
        .live_q   (live_ptrs),
        .init_q   (init_ptr),
        .at_bound (at_bound)
    );

    // read multiplexer: selected register or zero
    always_comb begin
        unique case (rsel)
            SEL_CSR:   bus_rdata = {{(DATA_W-FLAG_W){1'b0}}, flags_q};
            SEL_NEXT:  bus_rdata = live_ptrs[PIX_NEXT];
            SEL_LIMIT: bus_rdata = live_ptrs[PIX_LIMIT];
            SEL_START: bus_rdata = live_ptrs[PIX_START];
            SEL_STOP:  bus_rdata = live_ptrs[PIX_STOP];
            SEL_INIT:  bus_rdata = init_ptr;
            default:   bus_rdata = '0;
        endcase
    end

    assign chan_en  = flags_q.en;
    assign chan_dir = flags_q.dir;
    assign cur_ptr  = live_ptrs[PIX_NEXT];

endmodule

// File: rtl/dma_chan_regs_chk.sv
// Module: property checker for the DMA channel register block, bound to the top.
// Assumes the status layout dir/en/upd/done in bits 0..3.
module dma_chan_regs_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              xfer_beat,
    input logic              irq_pulse,
    input logic [DATA_W-1:0] cur_ptr,
    input logic [3:0]        flags,
    input logic [DATA_W-1:0] lim
);

    logic wr_word, csr_w, rst_w, clr_w, next_w;

    assign wr_word = bus_sel && bus_wr && (bus_size == 2'd2);
    assign csr_w   = wr_word && (bus_addr == '0);
    assign rst_w   = csr_w && bus_wdata[4];
    assign clr_w   = csr_w && bus_wdata[3];
    assign next_w  = wr_word && (bus_addr == ADDR_W'(32'h4000));

    assert_reset_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_w |=> (flags == 4'b0000));

    assert_dir_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !rst_w) |=> flags[0]);

    assert_irq_on_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_beat && flags[1] && !rst_w && !clr_w && (cur_ptr + 32'd4 == lim))
        |=> (irq_pulse && flags[3]));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[1] && !next_w) |=> $stable(cur_ptr));

    assert_narrow_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_size != 2'd2) && !xfer_beat)
        |=> ($stable(flags) && $stable(cur_ptr)));

    assert_rdata_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |-> (bus_rdata == '0));

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .xfer_beat (xfer_beat),
    .irq_pulse (irq_pulse),
    .cur_ptr   (cur_ptr),
    .flags     (flags_q),
    .lim       (live_ptrs[1])
);

// File: tb/tb_dma_chan_regs.sv
// Bench: behavioural reference model compared on every clock, plus directed reads.
module tb_dma_chan_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, xfer_beat = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, cur_ptr;
    logic        chan_en, chan_dir, irq_pulse;

    always #5 clk = ~clk;

    dma_chan_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .xfer_beat(xfer_beat), .chan_en(chan_en),
        .chan_dir(chan_dir), .cur_ptr(cur_ptr), .irq_pulse(irq_pulse)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model state
    bit          m_en, m_upd, m_dir, m_done, m_irq;
    logic [31:0] m_live[4];
    logic [31:0] m_sav[4];
    logic [31:0] m_init;

    function automatic int ptr_idx(logic [15:0] a);
        case (a)
            16'h4000: return 0;
            16'h4004: return 1;
            16'h4008: return 2;
            16'h400C: return 3;
            default:  return -1;
        endcase
    endfunction

    function automatic logic [31:0] m_read();
        if (!(bus_sel && !bus_wr && bus_size == 2'd2)) return 32'h0;
        if (bus_addr == 16'h0) return {28'h0, m_done, m_upd, m_en, m_dir};
        if (bus_addr == 16'h4200) return m_init;
        if (ptr_idx(bus_addr) >= 0) return m_live[ptr_idx(bus_addr)];
        return 32'h0;
    endfunction

    // model update on each rising edge
    always @(posedge clk) begin : model
        bit old_upd, wrw, csrw, rcmd, adv;
        logic [31:0] nx;
        int pi;
        if (!rst_n) begin
            m_en = 0; m_upd = 0; m_dir = 0; m_done = 0; m_irq = 0; m_init = 0;
            for (int k = 0; k < 4; k++) begin m_live[k] = 0; m_sav[k] = 0; end
        end else begin
            old_upd = m_upd;
            wrw  = bus_sel && bus_wr && bus_size == 2'd2;
            csrw = wrw && bus_addr == 16'h0;
            rcmd = csrw && bus_wdata[4];
            adv  = xfer_beat && m_en && !rcmd;
            m_irq = 0;
            if (adv) begin
                nx = m_live[0] + 32'd4;
                if (nx == m_live[1]) begin
                    m_done = 1; m_irq = 1;
                    m_live[0] = nx;
                    if (old_upd) begin
                        for (int k = 0; k < 4; k++) m_live[k] = m_sav[k];
                        m_upd = 0;
                    end else m_en = 0;
                end else m_live[0] = nx;
            end
            if (csrw) begin
                if (rcmd) begin m_en = 0; m_upd = 0; m_dir = 0; m_done = 0; end
                else begin
                    if (bus_wdata[0]) m_dir = 1;
                    if (bus_wdata[1]) m_en = 1;
                    if (bus_wdata[2]) m_upd = 1;
                    if (bus_wdata[3]) m_done = 0;
                end
            end
            pi = ptr_idx(bus_addr);
            if (wrw && pi >= 0) begin
                if (old_upd) m_sav[pi] = bus_wdata;
                else         m_live[pi] = bus_wdata;
            end
            if (wrw && bus_addr == 16'h4200) m_init = bus_wdata;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #3;
        if (rst_n && !finished) begin
            chk("R9 R11 cycle cur_ptr", cur_ptr, m_live[0]);
            chk("R10 cycle irq", {31'h0, irq_pulse}, {31'h0, m_irq});
            chk("R3 cycle enable", {31'h0, chan_en}, {31'h0, m_en});
            chk("R2 cycle dir", {31'h0, chan_dir}, {31'h0, m_dir});
            chk("R6 R12 cycle rdata", bus_rdata, m_read());
        end
    end

    task automatic wr(logic [15:0] a, logic [31:0] d, logic [1:0] sz = 2'd2);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_size = 2'd2;
    endtask

    task automatic rd(logic [15:0] a, logic [31:0] exp, string req, logic [1:0] sz = 2'd2);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a; bus_size = sz;
        #3 chk(req, bus_rdata, exp);
    endtask

    task automatic beat();
        @(negedge clk);
        bus_sel = 0; xfer_beat = 1;
        @(negedge clk);
        xfer_beat = 0;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #3;
        chk("R1 irq after reset", {31'h0, irq_pulse}, 32'h0);
        rd(16'h0000, 32'h0, "R1 control after reset");
        rd(16'h4000, 32'h0, "R1 next after reset");
        rd(16'h4200, 32'h0, "R1 init after reset");

        wr(16'h4000, 32'h1000); wr(16'h4004, 32'h1010);
        wr(16'h4008, 32'h1000); wr(16'h400C, 32'h1010);
        wr(16'h4200, 32'hABCD0000);
        rd(16'h4000, 32'h1000, "R7 next");
        rd(16'h4004, 32'h1010, "R7 limit");
        rd(16'h4008, 32'h1000, "R7 start");
        rd(16'h400C, 32'h1010, "R7 stop");
        rd(16'h4200, 32'hABCD0000, "R7 init");
        rd(16'h4010, 32'h0, "R12 unmapped read");
        wr(16'h4004, 32'hFFFF, 2'd1);
        rd(16'h4004, 32'h1010, "R12 narrow write ignored");

        beat();
        rd(16'h4000, 32'h1000, "R9 beat while disabled");

        wr(16'h0000, 32'h1);
        rd(16'h0000, 32'h1, "R2 dir set");
        wr(16'h0000, 32'h0);
        rd(16'h0000, 32'h1, "R2 dir kept on zero write");
        wr(16'h0000, 32'h2);
        rd(16'h0000, 32'h3, "R3 enable set");

        beat(); beat(); beat();
        rd(16'h4000, 32'h100C, "R9 three beats");
        beat();
        #3 chk("R10 irq after boundary", {31'h0, irq_pulse}, 32'h1);
        rd(16'h0000, 32'h9, "R10 R11 done set enable cleared");
        rd(16'h4000, 32'h1010, "R11 next holds limit");
        chk("R10 irq one cycle", {31'h0, irq_pulse}, 32'h0);
        rd(16'h0000, 32'h0, "R12 narrow read zero", 2'd0);
        wr(16'h0000, 32'h8);
        rd(16'h0000, 32'h1, "R4 clear complete");

        wr(16'h4000, 32'h3000); wr(16'h4004, 32'h3008);
        wr(16'h0000, 32'h4);
        rd(16'h0000, 32'h5, "R3 chain-update set");
        wr(16'h4000, 32'h2000); wr(16'h4004, 32'h2004);
        wr(16'h4008, 32'h2000); wr(16'h400C, 32'h2004);
        rd(16'h4000, 32'h3000, "R8 live next kept");
        rd(16'h4004, 32'h3008, "R8 live limit kept");
        wr(16'h0000, 32'h2);
        rd(16'h0000, 32'h7, "R3 enable with update");
        beat(); beat();
        #3 chk("R10 irq chained boundary", {31'h0, irq_pulse}, 32'h1);
        rd(16'h4000, 32'h2000, "R11 next reloaded");
        rd(16'h4004, 32'h2004, "R11 limit reloaded");
        rd(16'h400C, 32'h2004, "R11 stop reloaded");
        rd(16'h0000, 32'hB, "R11 update cleared enable kept");
        beat();
        rd(16'h0000, 32'h9, "R11 stop without update");
        rd(16'h4000, 32'h2004, "R11 next at limit");

        wr(16'h0000, 32'h2);
        rd(16'h0000, 32'hB, "R3 re-enable");
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 16'h0; bus_wdata = 32'h12; bus_size = 2'd2;
        xfer_beat = 1;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; xfer_beat = 0;
        #3 chk("R5 irq suppressed", {31'h0, irq_pulse}, 32'h0);
        rd(16'h0000, 32'h0, "R5 reset wins over set-enable");
        rd(16'h4000, 32'h2004, "R5 beat ignored in reset cycle");
        wr(16'h0000, 32'h7);
        wr(16'h0000, 32'h1F);
        rd(16'h0000, 32'h0, "R5 all bits at once");
        rd(16'h4200, 32'hABCD0000, "R7 init untouched");

        @(negedge clk);
        bus_sel = 0;
        repeat (2) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule